// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Stochastic Neuron

This block is an SPI slave that holds the configuration byte map of a stochastic leaky integrate-and-fire neuron. An external master sends 16-bit frames in SPI mode 0, most significant bit first, while the active-low select is held low. The first byte holds a read/write flag and a 4-bit address. The second byte carries the data. On a write the slave stores that data. On a read it returns the addressed byte on MISO.

The four serial pins are oversampled by the system clock through synchronisers. All register fields therefore come out in the system clock domain. The map has six kinds of content: a control byte (run enable, free-run select, refractory length), a 16-bit LFSR tap polynomial, a 16-bit seed, a threshold byte, a decay byte and eight activation-table bytes. One further address reads back a live status byte supplied by the neuron.

Two side effects produce single-cycle pulses. Writing the high seed byte requests a seed load. Setting the clear bit in the control byte requests a membrane reset.

Top module: `spi_regfile`

## Requirements
- R1: After reset every stored byte reads as zero, all field outputs and pulse outputs are low, and `miso_oe_o` is low.
- R2: A frame is 16 bits, sampled on SCK rising edges, MSB first. In byte 0, bit 7 is 1 for read and 0 for write, bits [6:4] are zero, and bits [3:0] are the address. Byte 1 is the data.
- R3: A write stores the data byte and updates its field outputs, as follows:
  - Address 0: bit 0 drives `run_en_o`, bit 2 drives `free_run_o`, and bits [7:5] drive `refrac_len_o`.
  - Polynomial: 1 is the low byte and 2 the high byte of `lfsr_poly_o`.
  - Seed: 3 is the low byte and 4 the high byte of `lfsr_seed_o`.
  - 5 drives `threshold_o` and 6 drives `decay_o`.
  - Address 8+k drives `act_table_o[8k+7:8k]`.
- R4: A read returns the addressed byte on MISO during byte 1, MSB first, changed on SCK falling edges. Address 0 reads back with bits 1, 3 and 4 as zero.
- R5: A read of address 7 returns `status_i`. A write to address 7 changes no stored byte and no output.
- R6: A write takes effect only if the 16th rising edge arrives while select is low. A frame aborted earlier changes nothing.
- R7: A write to address 4 gives exactly one `seed_load_o` cycle. A write to address 3 gives none.
- R8: A write to address 0 with data bit 1 set gives exactly one `accum_clear_o` cycle. That bit is not stored.
- R9: `miso_oe_o` is high only while the synchronised select is low. `miso_o` is low whenever it is not enabled, and also during byte 0.
- R10: A read frame changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master |
| csn_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for MISO pad |
| status_i | input | 8 | Live neuron status byte read at address 7 |
| run_en_o | output | 1 | Neuron run enable |
| free_run_o | output | 1 | Free-run select |
| refrac_len_o | output | 3 | Refractory length in cycles |
| accum_clear_o | output | 1 | One-cycle membrane clear request |
| lfsr_poly_o | output | 16 | LFSR tap polynomial |
| lfsr_seed_o | output | 16 | LFSR seed value |
| seed_load_o | output | 1 | One-cycle seed load request |
| threshold_o | output | 8 | Firing threshold |
| decay_o | output | 8 | Leak per cycle |
| act_table_o | output | 64 | Eight activation-table bytes, entry k at [8k+7:8k] |

## Verification
Each serial edge reaches the frame logic three clock cycles after the pin changes: two synchroniser flops and one edge-detect flop. A committed write appears on the field outputs two cycles after that, so about five cycles after the 16th rising edge. Read data is loaded about four cycles after the eighth falling edge. The bench holds every SCK phase for six system cycles and samples MISO at the end of a low phase, just before raising SCK. It checks fields and pulse counts only after select has been high for several more cycles. Pulse widths are measured by counting every clock cycle on which a strobe is high, so a pulse longer than one cycle shows up as a count mismatch.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int NREG       = 1 << ADDR_W;
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int LUT_N      = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_POLY_L = 4'd1;
  localparam logic [ADDR_W-1:0] A_POLY_H = 4'd2;
  localparam logic [ADDR_W-1:0] A_SEED_L = 4'd3;
  localparam logic [ADDR_W-1:0] A_SEED_H = 4'd4;
  localparam logic [ADDR_W-1:0] A_THR    = 4'd5;
  localparam logic [ADDR_W-1:0] A_DECAY  = 4'd6;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd7;
  localparam int                LUT_BASE = 8;

  // control byte: stored bits (enable, free run, refractory length)
  localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hE5;
  localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic mosi_s
);
  // pin order in the chain: {mosi, csn, sck}; select idles high
  localparam logic [2:0] PIN_RST = 3'b010;

  logic [2:0] chain_q [STAGES];
  logic       sck_prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [2:0] d;
    if (s == 0) begin : g_first
      assign d = {mosi_i, csn_i, sck_i};
    end else begin : g_next
      assign d = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= PIN_RST;
      else        chain_q[s] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= chain_q[STAGES-1][0];
  end

  assign sck_rise = chain_q[STAGES-1][0] & ~sck_prev_q;
  assign sck_fall = ~chain_q[STAGES-1][0] & sck_prev_q;
  assign sel      = ~chain_q[STAGES-1][1];
  assign mosi_s   = chain_q[STAGES-1][2];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso_bit
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int SH_W  = FRAME_BITS - 1;
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SH_W-1:0]   sh_q, sh_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic              wr_stb_n;
  logic [ADDR_W-1:0] wr_addr_n;
  logic [DATA_W-1:0] wr_data_n;

  // after 8 rising edges the header byte sits in sh_q[7:0]
  assign rd_addr  = sh_q[ADDR_W-1:0];
  assign miso_bit = tx_q[DATA_W-1];

  always_comb begin
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    tx_n      = tx_q;
    wr_stb_n  = 1'b0;
    wr_addr_n = wr_addr;
    wr_data_n = wr_data;
    if (!sel) begin
      cnt_n = '0;
      tx_n  = '0;
    end else begin
      if (sck_rise && cnt_q < CNT_END) begin
        sh_n  = {sh_q[SH_W-2:0], mosi_s};
        cnt_n = cnt_q + 1'b1;
        // 16th bit: header rw flag at sh_q[14], address at sh_q[10:7]
        if (cnt_q == CNT_LAST && !sh_q[SH_W-1]) begin
          wr_stb_n  = 1'b1;
          wr_addr_n = sh_q[DATA_W-1+ADDR_W-1:DATA_W-1];
          wr_data_n = {sh_q[DATA_W-2:0], mosi_s};
        end
      end
      if (sck_fall) begin
        if (cnt_q == CNT_HDR)     tx_n = sh_q[DATA_W-1] ? rd_data : '0;
        else if (cnt_q > CNT_HDR) tx_n = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      tx_q    <= tx_n;
      wr_stb  <= wr_stb_n;
      wr_addr <= wr_addr_n;
      wr_data <= wr_data_n;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_END); // R2
  AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(sel)); // R6
  AST_MISO_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cnt_q < CNT_HDR) |-> !miso_bit); // R9
endmodule

// File: rtl/spireg_store.sv
module spireg_store
  import spireg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [DATA_W-1:0]       status_i,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    run_en_o,
  output logic                    free_run_o,
  output logic [2:0]              refrac_len_o,
  output logic                    accum_clear_o,
  output logic [2*DATA_W-1:0]     lfsr_poly_o,
  output logic [2*DATA_W-1:0]     lfsr_seed_o,
  output logic                    seed_load_o,
  output logic [DATA_W-1:0]       threshold_o,
  output logic [DATA_W-1:0]       decay_o,
  output logic [LUT_N*DATA_W-1:0] act_table_o
);
  logic [NREG-1:0][DATA_W-1:0] regs_q, regs_n;
  logic                        wr_en;
  logic                        seed_n, clr_n;

  assign wr_en = wr_stb && (wr_addr != A_STATUS);

  always_comb begin
    regs_n = regs_q;
    if (wr_en) begin
      if (wr_addr == A_CTRL) regs_n[wr_addr] = wr_data & CTRL_KEEP;
      else                   regs_n[wr_addr] = wr_data;
    end
    seed_n = wr_stb && (wr_addr == A_SEED_H);
    clr_n  = wr_stb && (wr_addr == A_CTRL) && wr_data[CTRL_CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q        <= '0;
      seed_load_o   <= 1'b0;
      accum_clear_o <= 1'b0;
    end else begin
      if (wr_en) regs_q <= regs_n;
      seed_load_o   <= seed_n;
      accum_clear_o <= clr_n;
    end
  end

  assign rd_data      = (rd_addr == A_STATUS) ? status_i : regs_q[rd_addr];
  assign run_en_o     = regs_q[A_CTRL][0];
  assign free_run_o   = regs_q[A_CTRL][2];
  assign refrac_len_o = regs_q[A_CTRL][7:5];
  assign lfsr_poly_o  = {regs_q[A_POLY_H], regs_q[A_POLY_L]};
  assign lfsr_seed_o  = {regs_q[A_SEED_H], regs_q[A_SEED_L]};
  assign threshold_o  = regs_q[A_THR];
  assign decay_o      = regs_q[A_DECAY];

  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    assign act_table_o[k*DATA_W +: DATA_W] = regs_q[LUT_BASE + k];
  end

  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == A_STATUS) |=> $stable(regs_q)); // R5
  AST_SEED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_o |=> !seed_load_o); // R7
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accum_clear_o |=> !accum_clear_o); // R8
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_q)); // R10
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spireg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        csn_i,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  input  logic [7:0]  status_i,
  output logic        run_en_o,
  output logic        free_run_o,
  output logic [2:0]  refrac_len_o,
  output logic        accum_clear_o,
  output logic [15:0] lfsr_poly_o,
  output logic [15:0] lfsr_seed_o,
  output logic        seed_load_o,
  output logic [7:0]  threshold_o,
  output logic [7:0]  decay_o,
  output logic [63:0] act_table_o
);
  logic              sck_rise, sck_fall, sel, mosi_s, miso_bit;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_stb;

  spi_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .csn_i(csn_i), .mosi_i(mosi_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel), .mosi_s(mosi_s)
  );

  spi_frame_engine u_frame (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel(sel), .mosi_s(mosi_s), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .miso_bit(miso_bit)
  );

  spireg_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .status_i(status_i),
    .rd_data(rd_data), .run_en_o(run_en_o), .free_run_o(free_run_o),
    .refrac_len_o(refrac_len_o), .accum_clear_o(accum_clear_o),
    .lfsr_poly_o(lfsr_poly_o), .lfsr_seed_o(lfsr_seed_o),
    .seed_load_o(seed_load_o), .threshold_o(threshold_o),
    .decay_o(decay_o), .act_table_o(act_table_o)
  );

  assign miso_oe_o = sel;
  assign miso_o    = sel & miso_bit;

  AST_SEED_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_o |-> $past(wr_stb && wr_addr == A_SEED_H)); // R7
endmodule

// File: tb/tb_spi_regfile.sv
module tb_spi_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic [7:0] status = 8'h00;
  logic run_en, free_run, accum_clear, seed_load;
  logic [2:0] refrac;
  logic [15:0] poly, seed;
  logic [7:0] thr, decay;
  logic [63:0] lut;

  int checks = 0, failures = 0;
  int seed_pulses = 0, clr_pulses = 0;
  int exp_seed = 0, exp_clr = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regfile dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .status_i(status),
    .run_en_o(run_en), .free_run_o(free_run), .refrac_len_o(refrac),
    .accum_clear_o(accum_clear), .lfsr_poly_o(poly), .lfsr_seed_o(seed),
    .seed_load_o(seed_load), .threshold_o(thr), .decay_o(decay),
    .act_table_o(lut)
  );

  always @(posedge clk) begin
    if (rst_n && seed_load)   seed_pulses++;
    if (rst_n && accum_clear) clr_pulses++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame; nbits < 16 aborts early; returns bits seen on MISO in byte 1
  task automatic frame(input logic [7:0] b0, input logic [7:0] b1,
                       input int nbits, output logic [7:0] rd);
    logic [15:0] w;
    w = {b0, b1};
    rd = '0;
    csn = 1'b0;
    wait_clk(HALF);
    chk("R9 oe while selected", 64'(miso_oe), 64'd1);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15-i];
      wait_clk(HALF);
      if (i < 8) begin
        if (miso !== 1'b0) begin
          chk("R9 miso low in header", 64'(miso), 64'd0);
        end
      end else begin
        rd[15-i] = miso;
      end
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(HALF + 4);
    chk("R9 oe off when idle", 64'(miso_oe), 64'd0);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic [7:0] dummy;
    frame({4'h0, 4'(a)}, d, 16, dummy);
    if (a != 7) model[a] = (a == 0) ? (d & 8'hE5) : d;
    if (a == 4) exp_seed++;
    if (a == 0 && d[1]) exp_clr++;
  endtask

  task automatic rd_chk(input int a, input string req);
    logic [7:0] got;
    frame({4'h8, 4'(a)}, 8'h00, 16, got);
    chk(req, 64'(got), 64'((a == 7) ? status : model[a]));
  endtask

  task automatic fields_chk(input string req);
    logic [63:0] exp_lut;
    for (int k = 0; k < 8; k++) exp_lut[k*8 +: 8] = model[8+k];
    chk({req, " run_en"},   64'(run_en),   64'(model[0][0]));
    chk({req, " free_run"}, 64'(free_run), 64'(model[0][2]));
    chk({req, " refrac"},   64'(refrac),   64'(model[0][7:5]));
    chk({req, " poly"},     64'(poly),     64'({model[2], model[1]}));
    chk({req, " seed"},     64'(seed),     64'({model[4], model[3]}));
    chk({req, " thr"},      64'(thr),      64'(model[5]));
    chk({req, " decay"},    64'(decay),    64'(model[6]));
    chk({req, " lut"},      lut,           exp_lut);
    chk({req, " seed pulses R7"},  64'(seed_pulses), 64'(exp_seed));
    chk({req, " clear pulses R8"}, 64'(clr_pulses),  64'(exp_clr));
  endtask

  initial begin
    logic [7:0] junk;
    logic [7:0] pats [4];
    pats[0] = 8'h5A; pats[1] = 8'hA5; pats[2] = 8'hFF; pats[3] = 8'h00;
    for (int a = 0; a < 16; a++) model[a] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    fields_chk("R1 reset");
    chk("R1 miso_oe", 64'(miso_oe), 64'd0);
    chk("R1 accum_clear", 64'(accum_clear), 64'd0);
    chk("R1 seed_load", 64'(seed_load), 64'd0);
    for (int a = 0; a < 16; a++) rd_chk(a, "R1 reset readback");

    // R2 R3 R4 R10 sweep of all addresses under several data patterns
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 16; a++) wr(a, pats[p] ^ 8'(a * 8'h13));
      fields_chk("R3 after sweep");
      for (int a = 0; a < 16; a++) rd_chk(a, "R4 readback");
      fields_chk("R10 after reads");
    end

    // R7 low seed byte alone gives no pulse
    wr(3, 8'h77);
    fields_chk("R7 low seed write");

    // R8 clear bit pulses and is not stored
    wr(0, 8'h02);
    fields_chk("R8 clear only");
    rd_chk(0, "R8 ctrl readback");

    // R5 status readback and ignored write
    status = 8'h3C;
    rd_chk(7, "R5 status read");
    wr(7, 8'hFF);
    fields_chk("R5 status write ignored");
    status = 8'hC3;
    rd_chk(7, "R5 status read live");

    // R6 aborted frames
    frame(8'h05, 8'hEE, 15, junk);
    fields_chk("R6 abort at 15");
    frame(8'h04, 8'h99, 10, junk);
    fields_chk("R6 abort at 10");
    rd_chk(5, "R6 thr readback");

    // R6 a complete frame after an abort still commits
    wr(5, 8'h81);
    fields_chk("R6 recovery write");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule